// File: doc/BRIEF.md
# Level-Sensitive Interrupt Source Controller

This block sits beside one bus unit and turns its level-sensitive interrupt lines into requests for an upstream presentation controller. Each input owns a vector entry holding a delivery priority and a destination server number. A separate enable register holds one bit per input. An input becomes eligible when three things are true: its level is high, its enable bit is set, and its priority is not the all-ones "masked" value. The eligible input with the lowest index is placed on a valid/ready request stream. The request carries a source number made of the unit identifier followed by the input index, along with that entry's priority and server number.

Once the presentation controller takes a request, that input is outstanding. It sends nothing further until the controller answers with an end-of-interrupt or a reject for the same source number. After an end-of-interrupt the input re-evaluates its level on the next clock edge. After a reject it waits one idle cycle first. Software configures the vector entries and enable bits through a flat register port with a write strobe and a combinational read.

Back-pressure on the request stream: once `req_valid` is high, the source, priority and server fields hold steady until the cycle in which `req_ready` is also high. `req_ready` may be held high at any time. In a cycle where a handshake occurs, the next eligible input may be loaded for the following cycle.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset every vector entry reads priority 0xFF and server 0, the enable register reads 0, and `req_valid` is low.
- R2: A write to address i (i < N_SRC) sets entry i with priority in data bits [7:0] and server in bits [15:8]. A write to address N_SRC sets the enable register, with bit i for input i. Reads return the same layout combinationally, and all other addresses read 0.
- R3: An eligible input is offered in the cycle after the edge that sees it eligible. `req_src` is {UNIT_ID, index}, and `req_prio`/`req_server` come from that input's entry.
- R4: An input whose entry priority is 0xFF is never offered, and `req_valid` never shows priority 0xFF. Changing the priority to any other value lets a held level be offered.
- R5: An input whose enable bit is 0 is never offered.
- R6: When several inputs are eligible, they are offered in ascending index order.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and all request fields stay stable.
- R8: An accepted source is not offered again until an end-of-interrupt or reject for it arrives.
- R9: After an end-of-interrupt for an outstanding source, that source is offered again one cycle after the end-of-interrupt edge if it is still eligible. If its level is low, it is not offered.
- R10: After a reject for an outstanding source, the output is idle for one further cycle. The source is offered on the cycle after that if it is still eligible.
- R11: An end-of-interrupt or reject is ignored if its unit field differs from UNIT_ID or if it names a source that is not outstanding. When both arrive for the same source in the same cycle, the reject wins.
- R12: `req_src` is never zero while `req_valid` is high (UNIT_ID is nonzero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (entries 0..N_SRC-1, enable at N_SRC) |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| irq_level | input | N_SRC | Level-sensitive interrupt inputs |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_src | output | SRC_W | Source number {UNIT_ID, index} |
| req_prio | output | PRIO_W | Priority of the offered source |
| req_server | output | SERVER_W | Destination server of the offered source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source number being ended |
| rej_valid | input | 1 | Reject strobe |
| rej_src | input | SRC_W | Source number being rejected |

## Verification
The bound checker watches several rules on every cycle, using only the block's ports:
- the request fields hold steady under back-pressure;
- no offered request shows the masked priority;
- every source number is nonzero and carries the unit identifier;
- no source is accepted a second time before an answer for it. The checker decides this by tracking outstanding sources from the handshakes and the answers.

Other behaviours can only be shown by the bench's scenarios:
- the exact cycle spacing after an end-of-interrupt and after a reject;
- the ascending-index ordering;
- the gating by enable bits and by priority rewrites;
- the filtering of answers with a foreign unit field or for idle sources;
- the register layout and the reset contents.

// File: rtl/isc_pkg.sv
package isc_pkg;

  // Life cycle of one interrupt input
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,  // may be picked when eligible
    SLOT_OFFER = 2'd1,  // sitting in the output register
    SLOT_WAIT  = 2'd2,  // accepted upstream, awaiting an answer
    SLOT_HOLD  = 2'd3   // rejected, one idle cycle before re-evaluation
  } slot_state_e;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/isc_vec_table.sv
module isc_vec_table #(
  parameter int N_SRC    = 8,
  parameter int PRIO_W   = 8,
  parameter int SERVER_W = 8,
  parameter int DATA_W   = 32,
  parameter int AW       = 4,
  parameter int IDX_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [AW-1:0]                      cfg_addr,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  output logic [DATA_W-1:0]                  cfg_rdata,
  output logic [N_SRC-1:0][PRIO_W-1:0]       prio_o,
  output logic [N_SRC-1:0][SERVER_W-1:0]     server_o,
  output logic [N_SRC-1:0]                   enable_o
);

  localparam logic [AW-1:0] EN_ADDR = AW'(N_SRC);

  // One priority/server pair per input
  for (genvar g = 0; g < N_SRC; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_o[g]   <= '1;
        server_o[g] <= '0;
      end else if (cfg_we && cfg_addr == AW'(g)) begin
        prio_o[g]   <= cfg_wdata[PRIO_W-1:0];
        server_o[g] <= cfg_wdata[PRIO_W +: SERVER_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= '0;
    end else if (cfg_we && cfg_addr == EN_ADDR) begin
      enable_o <= cfg_wdata[N_SRC-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < EN_ADDR) begin
      cfg_rdata[PRIO_W-1:0]         = prio_o[cfg_addr[IDX_W-1:0]];
      cfg_rdata[PRIO_W +: SERVER_W] = server_o[cfg_addr[IDX_W-1:0]];
    end else if (cfg_addr == EN_ADDR) begin
      cfg_rdata[N_SRC-1:0] = enable_o;
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:PRIO_W+SERVER_W];

endmodule

// File: rtl/isc_src_slot.sv
module isc_src_slot
  import isc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        level_i,
  input  logic        enable_i,
  input  logic        masked_i,
  input  logic        grant_i,
  input  logic        accept_i,
  input  logic        eoi_i,
  input  logic        rej_i,
  output logic        eligible_o,
  output slot_state_e state_o
);

  slot_state_e state_d;

  assign eligible_o = (state_o == SLOT_IDLE) && level_i && enable_i && !masked_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      SLOT_IDLE:  if (grant_i)  state_d = SLOT_OFFER;
      SLOT_OFFER: if (accept_i) state_d = SLOT_WAIT;
      SLOT_WAIT: begin
        if (rej_i)      state_d = SLOT_HOLD;
        else if (eoi_i) state_d = SLOT_IDLE;
      end
      SLOT_HOLD:  state_d = SLOT_IDLE;
      default:    state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_o <= SLOT_IDLE;
    else        state_o <= state_d;
  end

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // Lowest set bit wins
  assign onehot_o = req_i & (~req_i + N'(1));
  assign any_o    = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/isc_out_stage.sv
module isc_out_stage #(
  parameter int IDX_W    = 3,
  parameter int PRIO_W   = 8,
  parameter int SERVER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                any_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [PRIO_W-1:0]   prio_i,
  input  logic [SERVER_W-1:0] server_i,
  input  logic                ready_i,
  output logic                load_o,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [PRIO_W-1:0]   prio_o,
  output logic [SERVER_W-1:0] server_o
);

  assign load_o = any_i && (!valid_o || ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      idx_o    <= '0;
      prio_o   <= '0;
      server_o <= '0;
    end else if (load_o) begin
      valid_o  <= 1'b1;
      idx_o    <= idx_i;
      prio_o   <= prio_i;
      server_o <= server_i;
    end else if (ready_i) begin
      valid_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
  import isc_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int PRIO_W   = 8,
  parameter int SERVER_W = 8,
  parameter int UNIT_W   = 9,
  parameter logic [UNIT_W-1:0] UNIT_ID = 'h005,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = idx_bits(N_SRC),
  localparam int SRC_W   = UNIT_W + IDX_W,
  localparam int AW      = idx_bits(N_SRC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [N_SRC-1:0]    irq_level,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [SRC_W-1:0]    req_src,
  output logic [PRIO_W-1:0]   req_prio,
  output logic [SERVER_W-1:0] req_server,
  input  logic                eoi_valid,
  input  logic [SRC_W-1:0]    eoi_src,
  input  logic                rej_valid,
  input  logic [SRC_W-1:0]    rej_src
);

  logic [N_SRC-1:0][PRIO_W-1:0]   prio_q;
  logic [N_SRC-1:0][SERVER_W-1:0] server_q;
  logic [N_SRC-1:0]               enable_q;
  logic [N_SRC-1:0]               eligible, onehot;
  logic [IDX_W-1:0]               pick_idx, cur_idx;
  logic                           pick_any, load;
  slot_state_e                    slot_st [N_SRC];

  isc_vec_table #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .SERVER_W(SERVER_W),
    .DATA_W(DATA_W), .AW(AW), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .prio_o(prio_q), .server_o(server_q), .enable_o(enable_q)
  );

  // Answers from upstream only count when the unit field is ours
  logic eoi_unit_ok, rej_unit_ok;
  assign eoi_unit_ok = eoi_valid && (eoi_src[SRC_W-1:IDX_W] == UNIT_ID);
  assign rej_unit_ok = rej_valid && (rej_src[SRC_W-1:IDX_W] == UNIT_ID);

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    logic grant_g, accept_g, eoi_g, rej_g;
    assign grant_g  = load && onehot[g];
    assign accept_g = req_valid && req_ready && (cur_idx == IDX_W'(g));
    assign eoi_g    = eoi_unit_ok && (eoi_src[IDX_W-1:0] == IDX_W'(g));
    assign rej_g    = rej_unit_ok && (rej_src[IDX_W-1:0] == IDX_W'(g));

    isc_src_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .level_i(irq_level[g]), .enable_i(enable_q[g]), .masked_i(&prio_q[g]),
      .grant_i(grant_g), .accept_i(accept_g), .eoi_i(eoi_g), .rej_i(rej_g),
      .eligible_o(eligible[g]), .state_o(slot_st[g])
    );
  end

  isc_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(eligible), .onehot_o(onehot), .idx_o(pick_idx), .any_o(pick_any)
  );

  isc_out_stage #(.IDX_W(IDX_W), .PRIO_W(PRIO_W), .SERVER_W(SERVER_W)) u_out (
    .clk(clk), .rst_n(rst_n), .any_i(pick_any), .idx_i(pick_idx),
    .prio_i(prio_q[pick_idx]), .server_i(server_q[pick_idx]),
    .ready_i(req_ready), .load_o(load), .valid_o(req_valid),
    .idx_o(cur_idx), .prio_o(req_prio), .server_o(req_server)
  );

  assign req_src = {UNIT_ID, cur_idx};

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int PRIO_W   = 8,
  parameter int SERVER_W = 8,
  parameter int UNIT_W   = 9,
  parameter logic [UNIT_W-1:0] UNIT_ID = 'h005,
  parameter int IDX_W    = 3,
  parameter int SRC_W    = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [SRC_W-1:0]    req_src,
  input logic [PRIO_W-1:0]   req_prio,
  input logic [SERVER_W-1:0] req_server,
  input logic                eoi_valid,
  input logic [SRC_W-1:0]    eoi_src,
  input logic                rej_valid,
  input logic [SRC_W-1:0]    rej_src
);

  localparam int SLOTS = 1 << IDX_W;

  // Outstanding set rebuilt from port traffic alone
  logic [SLOTS-1:0] out_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      if (eoi_valid && eoi_src[SRC_W-1:IDX_W] == UNIT_ID)
        out_q[eoi_src[IDX_W-1:0]] <= 1'b0;
      if (rej_valid && rej_src[SRC_W-1:IDX_W] == UNIT_ID)
        out_q[rej_src[IDX_W-1:0]] <= 1'b0;
      if (req_valid && req_ready)
        out_q[req_src[IDX_W-1:0]] <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_prio) && $stable(req_server))); // R7
  AST_NO_MASKED_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_prio != {PRIO_W{1'b1}})); // R4
  AST_SRC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_src != '0)); // R12
  AST_UNIT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_src[SRC_W-1:IDX_W] == UNIT_ID)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !out_q[req_src[IDX_W-1:0]]); // R8

endmodule

bind isc_source_ctrl isc_checker #(
  .PRIO_W(PRIO_W), .SERVER_W(SERVER_W), .UNIT_W(UNIT_W), .UNIT_ID(UNIT_ID),
  .IDX_W(IDX_W), .SRC_W(SRC_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_prio(req_prio), .req_server(req_server),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .rej_valid(rej_valid), .rej_src(rej_src)
);

// File: tb/tb_isc_source_ctrl.sv
module tb_isc_source_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int UW         = 9;
  localparam int IW         = 3;
  localparam int SW         = UW + IW;
  localparam int AWB        = 4;
  localparam logic [UW-1:0] UNIT = 9'h005;
  localparam logic [AWB-1:0] EN_A = 4'd8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AWB-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [N-1:0]  irq_level = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [SW-1:0] req_src;
  logic [7:0]    req_prio, req_server;
  logic          eoi_valid = 1'b0, rej_valid = 1'b0;
  logic [SW-1:0] eoi_src = '0, rej_src = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_source_ctrl #(.N_SRC(N), .UNIT_W(UW), .UNIT_ID(UNIT), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_level(irq_level),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_prio(req_prio), .req_server(req_server),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .rej_valid(rej_valid), .rej_src(rej_src)
  );

  function automatic logic [SW-1:0] src_of(int idx);
    return {UNIT, IW'(idx)};
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [AWB-1:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd_chk(string tag, logic [AWB-1:0] a, logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic send_eoi(int idx, logic [UW-1:0] unit = UNIT);
    eoi_valid = 1'b1; eoi_src = {unit, IW'(idx)};
    step();
    eoi_valid = 1'b0;
  endtask

  task automatic send_rej(int idx);
    rej_valid = 1'b1; rej_src = src_of(idx);
    step();
    rej_valid = 1'b0;
  endtask

  task automatic accept();
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_valid after reset", 32'(req_valid), 0);
    cfg_rd_chk("R1 entry0 reset", 4'd0, 32'h0000_00FF);
    cfg_rd_chk("R1 entry7 reset", 4'd7, 32'h0000_00FF);
    cfg_rd_chk("R1 enable reset", EN_A, 32'h0);
  endtask

  task automatic t_regs();
    cfg_wr(4'd3, 32'h0000_2A10);
    cfg_rd_chk("R2 entry3 readback", 4'd3, 32'h0000_2A10);
    cfg_wr(EN_A, 32'h0000_000F);
    cfg_rd_chk("R2 enable readback", EN_A, 32'h0000_000F);
    cfg_rd_chk("R2 unmapped address", 4'd12, 32'h0);
    cfg_wr(EN_A, 32'h0);
  endtask

  task automatic t_basic();
    cfg_wr(4'd2, 32'h0000_4430);
    cfg_wr(EN_A, 32'h0000_0004);
    irq_level[2] = 1'b1;
    step();
    chk("R3 valid", 32'(req_valid), 1);
    chk("R3 src", 32'(req_src), 32'(src_of(2)));
    chk("R3 prio", 32'(req_prio), 32'h30);
    chk("R3 server", 32'(req_server), 32'h44);
    chk("R12 src nonzero", 32'(req_src == '0), 0);
    step(3);
    chk("R7 held valid", 32'(req_valid), 1);
    chk("R7 held src", 32'(req_src), 32'(src_of(2)));
    accept();
    chk("R8 no re-offer after accept", 32'(req_valid), 0);
    step(3);
    chk("R8 still quiet while outstanding", 32'(req_valid), 0);
    send_eoi(2);
    chk("R9 quiet on eoi edge", 32'(req_valid), 0);
    step();
    chk("R9 re-offer after eoi", 32'(req_valid), 1);
    chk("R9 re-offer src", 32'(req_src), 32'(src_of(2)));
    accept();
    irq_level[2] = 1'b0;
    send_eoi(2);
    step();
    chk("R9 no offer with level low", 32'(req_valid), 0);
  endtask

  task automatic t_reject();
    irq_level[2] = 1'b1;
    step();
    chk("R10 offered", 32'(req_valid), 1);
    accept();
    send_rej(2);
    chk("R10 quiet on reject edge", 32'(req_valid), 0);
    step();
    chk("R10 idle retry cycle", 32'(req_valid), 0);
    step();
    chk("R10 retried", 32'(req_valid), 1);
    chk("R10 retried src", 32'(req_src), 32'(src_of(2)));
    accept();
    irq_level[2] = 1'b0;
    send_eoi(2);
    step();
  endtask

  task automatic t_ignore();
    irq_level[2] = 1'b1;
    step();
    accept();
    send_eoi(2, UNIT ^ 9'h001);
    step();
    chk("R11 foreign unit eoi ignored", 32'(req_valid), 0);
    send_eoi(5);
    step();
    chk("R11 eoi to idle source ignored", 32'(req_valid), 0);
    send_eoi(2);
    step();
    chk("R11 proper eoi accepted", 32'(req_valid), 1);
    accept();
    irq_level[2] = 1'b0;
    send_eoi(2);
    step();
  endtask

  task automatic t_mask();
    cfg_wr(4'd2, 32'h0000_44FF);
    irq_level[2] = 1'b1;
    step(3);
    chk("R4 masked by 0xFF", 32'(req_valid), 0);
    cfg_wr(4'd2, 32'h0000_4420);
    step();
    chk("R4 unmasked offer", 32'(req_valid), 1);
    chk("R4 new prio", 32'(req_prio), 32'h20);
    accept();
    irq_level[2] = 1'b0;
    send_eoi(2);
    step();
  endtask

  task automatic t_enable();
    cfg_wr(EN_A, 32'h0);
    irq_level[2] = 1'b1;
    step(3);
    chk("R5 disabled no offer", 32'(req_valid), 0);
    cfg_wr(EN_A, 32'h0000_0004);
    step();
    chk("R5 enabled offer", 32'(req_valid), 1);
    accept();
    irq_level[2] = 1'b0;
    send_eoi(2);
    step();
  endtask

  task automatic t_order();
    cfg_wr(4'd1, 32'h0000_0110);
    cfg_wr(4'd4, 32'h0000_0410);
    cfg_wr(4'd6, 32'h0000_0610);
    cfg_wr(EN_A, 32'h0000_0052);
    irq_level = 8'b0101_0010;
    step();
    chk("R6 first lowest index", 32'(req_src), 32'(src_of(1)));
    req_ready = 1'b1;
    step();
    chk("R6 second", 32'(req_src), 32'(src_of(4)));
    chk("R6 second server", 32'(req_server), 32'h04);
    step();
    chk("R6 third", 32'(req_src), 32'(src_of(6)));
    step();
    chk("R6 drained", 32'(req_valid), 0);
    req_ready = 1'b0;
    irq_level = '0;
    send_eoi(1);
    send_eoi(4);
    send_eoi(6);
    step();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_basic();
    t_reject();
    t_ignore();
    t_mask();
    t_enable();
    t_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule